// File: doc/BRIEF.md
# Variable-Oversampling Serial Bit-Rate Generator

This block turns a fast core clock into the three timing enables that a high-speed asynchronous serial receiver and transmitter need: a sample enable at the oversampling rate, a bit enable once per bit period, and a strobe at the middle sample of each bit. The division happens in three cascaded stages. The first is a prescaler whose ratio is a power of four times two. The second is an 8-bit reload counter. The third counts samples per bit, and that count can be programmed instead of being fixed at sixteen.

Software sets the block up through a narrow write-only port that holds three registers: a mode register that carries the prescaler select, a divisor register, and a sampling register. When the receiver detects a start-bit edge, it pulses a resync input so that bit timing restarts from that edge. The bit period is S × 2^(2c+1) × (D + 1) core clocks, where S is the samples per bit, c is the prescaler select and D is the divisor.

Top module: `baud_gen`

## Requirements
- R1: After reset the divisor is 255, the prescaler select is 0 and the samples per bit are 16. The first sample tick comes 512 cycles after reset is released and the first bit tick 8192 cycles after. All outputs stay low while reset is asserted.
- R2: Bits [1:0] of the mode register (address 0) hold the prescaler select c, which divides by 2, 8, 32 or 128 for c = 0, 1, 2, 3. The other bits of the mode register have no effect.
- R3: Bits [7:0] of the divisor register (address 1) hold D, and the reload stage divides the prescaled clock by D + 1.
- R4: `sample_tick` is a one-cycle pulse that repeats every 2^(2c+1) × (D + 1) cycles. The first pulse is in the last cycle of the first such interval after a restart.
- R5: When bit 15 of the sampling register (address 2) is set, the samples per bit are S = field + 1, where the field is bits [4:0]. This covers 8 to 32 samples per bit, and a bit tick marks every S-th sample tick.
- R6: With bit 15 set, any field value below 7 is treated as 7, giving 8 samples per bit.
- R7: With bit 15 clear, the samples per bit are 16 and the field has no effect.
- R8: `mid_tick` fires together with the sample tick whose index within the bit equals floor(S/2), counting the first sample after a bit boundary as index 0. It never coincides with `bit_tick`.
- R9: `bit_tick` fires only together with the last sample tick of each bit, which is sample index S − 1.
- R10: A `resync` pulse clears all three counters. The next sample tick then comes one full sample interval after the cycle that follows the pulse.
- R11: Every write to addresses 0 to 2 restarts all counters, even when the value written is unchanged.
- R12: A write to address 3 changes nothing and does not restart the counters.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register select (0 mode, 1 divisor, 2 sampling) |
| wr_data | input | 16 | Write data |
| resync | input | 1 | Restart bit timing (start-bit edge) |
| sample_tick | output | 1 | Oversampling enable pulse |
| bit_tick | output | 1 | Bit-period enable pulse |
| mid_tick | output | 1 | Mid-bit sample strobe |

## Verification
The hardest case to reach is a restart that lands part-way through a bit. Here a stale sample count could leak into the next bit, and it only shows up when the prescaler and the reload counter are both in mid-count at the same moment. The stimulus reaches this case by pulsing resync, and by rewriting the divisor with the same value, at a spread of offsets inside a bit and with odd sample counts and non-trivial prescaler settings. A reference model works out the expected pulses arithmetically from the time since the last restart, and the bench compares all three outputs with it on every cycle.

// File: rtl/baud_pkg.sv
package baud_pkg;
   typedef enum logic [1:0] {
      REG_MODE = 2'd0,
      REG_DIV  = 2'd1,
      REG_SAMP = 2'd2,
      REG_NONE = 2'd3
   } reg_sel_e;

   // terminal count of the power-of-four prescaler for select value c
   function automatic int unsigned pre_term(input int unsigned c);
      return (32'd1 << (2 * c + 1)) - 32'd1;
   endfunction
endpackage

// File: rtl/baud_regs.sv
module baud_regs
   import baud_pkg::*;
#(
   parameter int ADDR_W      = 2,
   parameter int DATA_W      = 16,
   parameter int CKS_W       = 2,
   parameter int DIV_W       = 8,
   parameter int SCNT_W      = 5,
   parameter int SR_EN_BIT   = 15,
   parameter int SR_MIN      = 8,
   parameter int SR_FIXED    = 16,
   parameter int DIV_RESET   = 255,
   parameter int FLD_RESET   = 15,
   parameter bit PROG_SAMPLE = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   output logic [CKS_W-1:0]  cks,
   output logic [DIV_W-1:0]  divisor,
   output logic [SCNT_W-1:0] sr_last,
   output logic              restart
);
   localparam logic [SCNT_W-1:0] LAST_MIN   = SCNT_W'(SR_MIN - 1);
   localparam logic [SCNT_W-1:0] LAST_FIXED = SCNT_W'(SR_FIXED - 1);

   logic              hit_mode, hit_div, hit_samp;
   logic              samp_en_q;
   logic [SCNT_W-1:0] samp_fld_q;

   assign hit_mode = wr_en && (wr_addr == ADDR_W'(REG_MODE));
   assign hit_div  = wr_en && (wr_addr == ADDR_W'(REG_DIV));
   assign hit_samp = wr_en && (wr_addr == ADDR_W'(REG_SAMP));
   assign restart  = hit_mode | hit_div | hit_samp;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cks        <= '0;
         divisor    <= DIV_W'(DIV_RESET);
         samp_en_q  <= 1'b0;
         samp_fld_q <= SCNT_W'(FLD_RESET);
      end else begin
         if (hit_mode) cks     <= wr_data[CKS_W-1:0];
         if (hit_div)  divisor <= wr_data[DIV_W-1:0];
         if (hit_samp) begin
            samp_en_q  <= wr_data[SR_EN_BIT];
            samp_fld_q <= wr_data[SCNT_W-1:0];
         end
      end
   end

   generate
      if (PROG_SAMPLE) begin : g_prog
         always_comb begin
            if (!samp_en_q)                  sr_last = LAST_FIXED;
            else if (samp_fld_q < LAST_MIN)  sr_last = LAST_MIN;
            else                             sr_last = samp_fld_q;
         end
      end else begin : g_fixed
         assign sr_last = LAST_FIXED;
         logic unused_samp;
         assign unused_samp = samp_en_q ^ (^samp_fld_q);
      end
   endgenerate
endmodule

// File: rtl/baud_prescale.sv
module baud_prescale
   import baud_pkg::*;
#(
   parameter int CKS_W = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clear,
   input  logic [CKS_W-1:0] cks,
   output logic             pre_wrap
);
   localparam int NSEL  = 2 ** CKS_W;
   localparam int PRE_W = 2 * (NSEL - 1) + 1;

   logic [PRE_W-1:0] term_tab [NSEL];
   logic [PRE_W-1:0] cnt_q;
   logic [PRE_W-1:0] term;

   generate
      for (genvar i = 0; i < NSEL; i++) begin : g_term
         assign term_tab[i] = PRE_W'(pre_term(i));
      end
   endgenerate

   assign term     = term_tab[cks];
   assign pre_wrap = (cnt_q == term);

   always_ff @(posedge clk) begin
      if (!rst_n || clear)  cnt_q <= '0;
      else if (pre_wrap)    cnt_q <= '0;
      else                  cnt_q <= cnt_q + 1'b1;
   end
endmodule

// File: rtl/baud_reload.sv
module baud_reload #(
   parameter int DIV_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clear,
   input  logic             pre_wrap,
   input  logic [DIV_W-1:0] divisor,
   output logic             samp_tick
);
   logic [DIV_W-1:0] cnt_q;
   logic             at_end;

   assign at_end    = (cnt_q == divisor);
   assign samp_tick = pre_wrap && at_end;

   always_ff @(posedge clk) begin
      if (!rst_n || clear) cnt_q <= '0;
      else if (pre_wrap)   cnt_q <= at_end ? '0 : cnt_q + 1'b1;
   end
endmodule

// File: rtl/baud_sampler.sv
module baud_sampler #(
   parameter int SCNT_W = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clear,
   input  logic              samp_tick,
   input  logic [SCNT_W-1:0] sr_last,
   output logic              bit_tick,
   output logic              mid_tick
);
   logic [SCNT_W-1:0] cnt_q;
   logic [SCNT_W:0]   mid_idx;
   logic              at_last;

   assign mid_idx  = ({1'b0, sr_last} + 1'b1) >> 1;
   assign at_last  = (cnt_q == sr_last);
   assign bit_tick = samp_tick && at_last;
   assign mid_tick = samp_tick && ({1'b0, cnt_q} == mid_idx);

   always_ff @(posedge clk) begin
      if (!rst_n || clear) cnt_q <= '0;
      else if (samp_tick)  cnt_q <= at_last ? '0 : cnt_q + 1'b1;
   end
endmodule

// File: rtl/baud_gen.sv
module baud_gen #(
   parameter int CKS_W       = 2,
   parameter int DIV_W       = 8,
   parameter int SR_MIN      = 8,
   parameter int SR_MAX      = 32,
   parameter int SR_FIXED    = 16,
   parameter int SR_EN_BIT   = 15,
   parameter int DIV_RESET   = 255,
   parameter int FLD_RESET   = 15,
   parameter bit PROG_SAMPLE = 1'b1
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        wr_en,
   input  logic [1:0]  wr_addr,
   input  logic [15:0] wr_data,
   input  logic        resync,
   output logic        sample_tick,
   output logic        bit_tick,
   output logic        mid_tick
);
   localparam int ADDR_W = 2;
   localparam int DATA_W = 16;
   localparam int SCNT_W = $clog2(SR_MAX);

   generate
      if (SR_MIN < 4 || SR_MIN > SR_MAX) begin : g_bad_min
         $error("baud_gen: SR_MIN out of range");
      end
      if (SR_FIXED < SR_MIN || SR_FIXED > SR_MAX) begin : g_bad_fixed
         $error("baud_gen: SR_FIXED out of range");
      end
      if (SR_EN_BIT >= DATA_W || SR_EN_BIT < SCNT_W) begin : g_bad_en
         $error("baud_gen: enable bit overlaps field or exceeds data width");
      end
      if (DIV_W > DATA_W || CKS_W > 3) begin : g_bad_w
         $error("baud_gen: divisor or select width too wide");
      end
   endgenerate

   logic [CKS_W-1:0]  cks;
   logic [DIV_W-1:0]  divisor;
   logic [SCNT_W-1:0] sr_last;
   logic              restart, clear, pre_wrap;

   assign clear = restart | resync;

   baud_regs #(
      .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CKS_W(CKS_W), .DIV_W(DIV_W),
      .SCNT_W(SCNT_W), .SR_EN_BIT(SR_EN_BIT), .SR_MIN(SR_MIN),
      .SR_FIXED(SR_FIXED), .DIV_RESET(DIV_RESET), .FLD_RESET(FLD_RESET),
      .PROG_SAMPLE(PROG_SAMPLE)
   ) u_regs (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .cks(cks), .divisor(divisor), .sr_last(sr_last),
      .restart(restart)
   );

   baud_prescale #(.CKS_W(CKS_W)) u_pre (
      .clk(clk), .rst_n(rst_n), .clear(clear), .cks(cks), .pre_wrap(pre_wrap)
   );

   baud_reload #(.DIV_W(DIV_W)) u_rld (
      .clk(clk), .rst_n(rst_n), .clear(clear), .pre_wrap(pre_wrap),
      .divisor(divisor), .samp_tick(sample_tick)
   );

   baud_sampler #(.SCNT_W(SCNT_W)) u_smp (
      .clk(clk), .rst_n(rst_n), .clear(clear), .samp_tick(sample_tick),
      .sr_last(sr_last), .bit_tick(bit_tick), .mid_tick(mid_tick)
   );
endmodule

// File: rtl/baud_gen_chk.sv
module baud_gen_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       wr_en,
   input logic [1:0] wr_addr,
   input logic       resync,
   input logic       sample_tick,
   input logic       bit_tick,
   input logic       mid_tick
);
   AST_BIT_WITH_SAMPLE: assert property (@(posedge clk) disable iff (!rst_n)
      bit_tick |-> sample_tick); // R9
   AST_MID_WITH_SAMPLE: assert property (@(posedge clk) disable iff (!rst_n)
      mid_tick |-> sample_tick); // R8
   AST_MID_NOT_BIT: assert property (@(posedge clk) disable iff (!rst_n)
      !(mid_tick && bit_tick)); // R8
   AST_SAMPLE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      sample_tick |=> !sample_tick); // R4
   AST_RESYNC_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      resync |=> !sample_tick); // R10
   AST_WRITE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_addr != 2'd3) |=> !sample_tick); // R11
endmodule

bind baud_gen baud_gen_chk u_chk (
   .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
   .resync(resync), .sample_tick(sample_tick), .bit_tick(bit_tick),
   .mid_tick(mid_tick)
);

// File: tb/tb_baud_gen.sv
module tb_baud_gen;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [1:0]  wr_addr = 2'd0;
   logic [15:0] wr_data = 16'd0;
   logic        resync = 1'b0;
   logic        sample_tick, bit_tick, mid_tick;

   int tests = 0;
   int fails = 0;
   int cyc   = 0;
   string phase = "R1";

   // reference model state
   int m_p = 2, m_d = 255, m_s = 16, m_t = 0;

   always #5 clk = ~clk;

   baud_gen dut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .resync(resync), .sample_tick(sample_tick),
      .bit_tick(bit_tick), .mid_tick(mid_tick)
   );

   always @(posedge clk) begin
      cyc <= cyc + 1;
      if (!rst_n) begin
         m_p = 2; m_d = 255; m_s = 16; m_t = 0;
      end else if (wr_en && wr_addr != 2'd3) begin
         case (wr_addr)
            2'd0: m_p = 1 << (2 * int'(wr_data[1:0]) + 1);
            2'd1: m_d = int'(wr_data[7:0]);
            default: begin
               if (!wr_data[15]) m_s = 16;
               else if (wr_data[4:0] < 5'd7) m_s = 8;
               else m_s = int'(wr_data[4:0]) + 1;
            end
         endcase
         m_t = 0;
      end else if (resync) begin
         m_t = 0;
      end else begin
         m_t = m_t + 1;
      end
   end

   always @(negedge clk) begin
      int len, k;
      logic es, eb, em;
      len = m_p * (m_d + 1);
      es  = ((m_t + 1) % len) == 0;
      k   = (m_t + 1) / len;
      eb  = es && (k % m_s == 0);
      em  = es && ((k - 1) % m_s == m_s / 2);
      if (!rst_n) begin es = 0; eb = 0; em = 0; end
      tests += 3;
      if (sample_tick !== es) begin
         fails++;
         $display("FAIL R4 (phase %s) cyc %0d sample_tick act %b exp %b", phase, cyc, sample_tick, es);
      end
      if (bit_tick !== eb) begin
         fails++;
         $display("FAIL R9 (phase %s) cyc %0d bit_tick act %b exp %b", phase, cyc, bit_tick, eb);
      end
      if (mid_tick !== em) begin
         fails++;
         $display("FAIL R8 (phase %s) cyc %0d mid_tick act %b exp %b", phase, cyc, mid_tick, em);
      end
   end

   always @(posedge clk) begin
      if (cyc > 190000) begin
         fails++;
         $display("FAIL watchdog expired at cycle %0d", cyc);
         $display("[TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic wr(input logic [1:0] a, input logic [15:0] d);
      @(negedge clk); #1;
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      @(negedge clk); #1;
      wr_en = 1'b0; wr_data = 16'h0;
   endtask

   task automatic pulse_resync;
      @(negedge clk); #1;
      resync = 1'b1;
      @(negedge clk); #1;
      resync = 1'b0;
   endtask

   initial begin
      // R1: reset state and default timing
      phase = "R1";
      idle(5);
      @(negedge clk); #1; rst_n = 1'b1;
      idle(8400);

      // R3: divisor
      phase = "R3";
      wr(2'd1, 16'h0003);
      idle(400);
      wr(2'd1, 16'hFF00);
      idle(300);

      // R2: prescaler select, upper bits ignored
      phase = "R2";
      wr(2'd1, 16'h0001);
      for (int c = 0; c < 4; c++) begin
         wr(2'd0, 16'hA5F0 | 16'(c));
         idle(c == 3 ? 4300 : 1200);
      end

      // R5: programmable samples per bit
      phase = "R5";
      wr(2'd0, 16'h0000);
      wr(2'd1, 16'h0000);
      wr(2'd2, 16'h8007); idle(200);
      wr(2'd2, 16'h800C); idle(300);
      wr(2'd2, 16'h8014); idle(400);
      wr(2'd2, 16'h801F); idle(600);

      // R6: field below minimum clamps to 8
      phase = "R6";
      wr(2'd2, 16'h8003); idle(200);
      wr(2'd2, 16'h8000); idle(200);

      // R7: enable clear forces 16, field ignored
      phase = "R7";
      wr(2'd2, 16'h0005); idle(300);
      wr(2'd2, 16'h001F); idle(300);

      // R10: resync at varied offsets, odd sample count, prescale 8
      phase = "R10";
      wr(2'd0, 16'h0001);
      wr(2'd1, 16'h0002);
      wr(2'd2, 16'h800C);
      for (int i = 0; i < 12; i++) begin
         idle(17 + i * 23);
         pulse_resync();
      end
      idle(800);

      // R11: rewriting an unchanged value restarts timing
      phase = "R11";
      for (int i = 0; i < 6; i++) begin
         idle(31 + i * 41);
         wr(2'd1, 16'h0002);
      end
      idle(500);

      // R12: unmapped address has no effect
      phase = "R12";
      for (int i = 0; i < 5; i++) begin
         idle(29 + i * 37);
         wr(2'd3, 16'hFFFF);
      end
      idle(800);

      // R8: mid strobe with even and odd counts under a larger divide
      phase = "R8";
      wr(2'd0, 16'h0000);
      wr(2'd1, 16'h0004);
      wr(2'd2, 16'h8008); idle(300);
      wr(2'd2, 16'h8009); idle(300);

      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end
endmodule